// File: doc/BRIEF.md
# Negative Delta-V Termination Detector

This block watches the open-circuit voltage of one NiMH cell during fast charge and decides when fast charge must end. It receives digitised voltage samples with a valid strobe, a flag that is high while fast charge runs, a periodic base tick, and a drop threshold that can be programmed. It emits a one-cycle terminate pulse and a cause code. The cause code names either a voltage drop from the peak or a voltage that has stayed flat for too long.

After fast charge starts, nothing is judged until a hold-off of `HOLD_TICKS` base ticks has elapsed. From then on, one sample slot opens every `SAMPLE_TICKS` ticks. The charge-pulse logic around the block strobes the sample while the pulse is off. The block keeps the running peak of the accepted samples. It ends fast charge when a sample falls below that peak by at least the threshold. It also ends fast charge when the peak has not moved for `FLAT_TICKS` ticks. All time constants are counted in base ticks. The defaults (250, 32 and 1000) match 4 minutes, 32 ticks and 16 minutes at a 0.96 s tick.

Top module: `ndv_term_detect`

## Requirements
- R1: Out of reset, and whenever fast charge is inactive, `term_o` is 0. After reset `cause_o` is 2'b00, which means no cause.
- R2: No sample is accepted before the `HOLD_TICKS`-th base tick counted from the cycle in which `fast_active_i` became high.
- R3: The first slot opens at the end of the hold-off, and a new slot opens every `SAMPLE_TICKS` ticks after it. Each slot accepts only the first valid sample. A further strobe in the same slot is ignored.
- R4: The first accepted sample loads the peak unconditionally. A later accepted sample that is strictly greater than the peak replaces it.
- R5: An accepted sample that does not exceed the peak, and lies below the peak by at least `thr_i`, ends fast charge with cause 2'b01 (voltage drop).
- R6: If the peak has not been loaded or replaced for `FLAT_TICKS` ticks since its last update, fast charge ends with cause 2'b10 (flat voltage).
- R7: `term_o` is a pulse one clock cycle wide. It appears in the cycle after the deciding sample or tick, and at most once per fast-charge run.
- R8: `cause_o` holds its value after a termination, including after `fast_active_i` falls. It clears to 2'b00 in the cycle after the next rising edge of `fast_active_i`.
- R9: When `fast_active_i` deasserts, the peak, the flat timer, the hold-off count and the slot timing are all cleared. A new run does not compare against the peak of the previous run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Base tick, one cycle wide per period |
| fast_active_i | input | 1 | High while fast charge is in progress |
| sample_valid_i | input | 1 | Strobe for `sample_i` |
| sample_i | input | VW | Unsigned cell-voltage code, 0.5 mV per LSB |
| thr_i | input | VW | Drop threshold in LSB (4 for 2 mV) |
| term_o | output | 1 | One-cycle pulse that ends fast charge |
| cause_o | output | 2 | 00 none, 01 voltage drop, 10 flat voltage |

## Verification
The hardest state to reach is a flat-voltage timeout racing a new sample slot. The timeout expires on the same tick that opens the next slot, so the flat ending must win before a sample can be accepted. The bench reaches this with sequences that rise once and then hover inside the threshold band. It uses shortened tick parameters in which the flat window is an exact multiple of the slot interval, so the timeout lands on a slot boundary. Further directed runs place a strobe one tick before the end of the hold-off and a second strobe in the same slot, and confirm that neither alters the peak.

// File: rtl/ndv_pkg.sv
package ndv_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE = 2'b00,
      CAUSE_DROP = 2'b01,
      CAUSE_FLAT = 2'b10
   } cause_t;
endpackage

// File: rtl/ndv_slot_gate.sv
module ndv_slot_gate #(
   parameter int HOLD_TICKS   = 250,
   parameter int SAMPLE_TICKS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic tick_i,
   input  logic take_i,
   output logic hold_done_o,
   output logic slot_open_o
);
   localparam int HW = $clog2(HOLD_TICKS + 1);

   logic [HW-1:0] hold_cnt;
   logic          hold_done;
   logic          slot_open;
   logic          slot_wrap;
   logic          hold_last;

   assign hold_last = (hold_cnt == HW'(HOLD_TICKS - 1));

   // slot cadence: a counter, or every tick when the interval is one
   generate
      if (SAMPLE_TICKS == 1) begin : g_every_tick
         assign slot_wrap = tick_i;
      end else begin : g_counted
         localparam int SW = $clog2(SAMPLE_TICKS);
         logic [SW-1:0] slot_cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !en_i || !hold_done) begin
               slot_cnt <= '0;
            end else if (tick_i) begin
               if (slot_cnt == SW'(SAMPLE_TICKS - 1)) slot_cnt <= '0;
               else                                   slot_cnt <= slot_cnt + 1'b1;
            end
         end
         assign slot_wrap = tick_i && (slot_cnt == SW'(SAMPLE_TICKS - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i) begin
         hold_cnt  <= '0;
         hold_done <= 1'b0;
         slot_open <= 1'b0;
      end else if (!hold_done) begin
         if (tick_i) begin
            if (hold_last) begin
               hold_done <= 1'b1;
               slot_open <= 1'b1;
            end else begin
               hold_cnt <= hold_cnt + 1'b1;
            end
         end
      end else begin
         if (slot_wrap)   slot_open <= 1'b1;
         else if (take_i) slot_open <= 1'b0;
      end
   end

   assign hold_done_o = hold_done;
   assign slot_open_o = slot_open;
endmodule

// File: rtl/ndv_peak_track.sv
module ndv_peak_track #(
   parameter int VW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          take_i,
   input  logic [VW-1:0] sample_i,
   input  logic [VW-1:0] thr_i,
   output logic          load_o,
   output logic          drop_o
);
   logic [VW-1:0] peak;
   logic          have_peak;
   logic          rise;
   logic [VW-1:0] gap;

   assign rise   = sample_i > peak;
   assign gap    = peak - sample_i;
   assign load_o = take_i && (!have_peak || rise);
   assign drop_o = take_i && have_peak && !rise && (gap >= thr_i);

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i) begin
         peak      <= '0;
         have_peak <= 1'b0;
      end else if (load_o) begin
         peak      <= sample_i;
         have_peak <= 1'b1;
      end
   end
endmodule

// File: rtl/ndv_flat_timer.sv
module ndv_flat_timer #(
   parameter int FLAT_TICKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic tick_i,
   input  logic restart_i,
   output logic expire_o
);
   localparam int FW = $clog2(FLAT_TICKS + 1);

   logic [FW-1:0] cnt;
   logic          running;

   assign expire_o = running && tick_i && !restart_i &&
                     (cnt == FW'(FLAT_TICKS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i) begin
         cnt     <= '0;
         running <= 1'b0;
      end else if (restart_i) begin
         cnt     <= '0;
         running <= 1'b1;
      end else if (running && tick_i) begin
         if (cnt == FW'(FLAT_TICKS - 1)) begin
            cnt     <= '0;
            running <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ndv_term_detect.sv
module ndv_term_detect #(
   parameter int VW           = 16,
   parameter int HOLD_TICKS   = 250,
   parameter int SAMPLE_TICKS = 32,
   parameter int FLAT_TICKS   = 1000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          fast_active_i,
   input  logic          sample_valid_i,
   input  logic [VW-1:0] sample_i,
   input  logic [VW-1:0] thr_i,
   output logic          term_o,
   output logic [1:0]    cause_o
);
   import ndv_pkg::*;

   generate
      if (VW < 2)           begin : g_bad_vw    $error("VW must be at least 2");           end
      if (HOLD_TICKS < 1)   begin : g_bad_hold  $error("HOLD_TICKS must be at least 1");   end
      if (SAMPLE_TICKS < 1) begin : g_bad_slot  $error("SAMPLE_TICKS must be at least 1"); end
      if (FLAT_TICKS < 1)   begin : g_bad_flat  $error("FLAT_TICKS must be at least 1");   end
   endgenerate

   logic   done_q;
   logic   fa_q;
   logic   go;
   logic   hold_done;
   logic   slot_open;
   logic   take;
   logic   load_ev;
   logic   drop_ev;
   logic   flat_ev;
   logic   drop_hit;
   logic   flat_hit;
   cause_t cause_q;

   assign go       = fast_active_i && !done_q;
   assign take     = go && slot_open && sample_valid_i;
   assign drop_hit = drop_ev;
   assign flat_hit = go && flat_ev && !drop_hit;

   ndv_slot_gate #(
      .HOLD_TICKS  (HOLD_TICKS),
      .SAMPLE_TICKS(SAMPLE_TICKS)
   ) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (go),
      .tick_i     (tick_i),
      .take_i     (take),
      .hold_done_o(hold_done),
      .slot_open_o(slot_open)
   );

   ndv_peak_track #(.VW(VW)) u_peak (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (go),
      .take_i  (take),
      .sample_i(sample_i),
      .thr_i   (thr_i),
      .load_o  (load_ev),
      .drop_o  (drop_ev)
   );

   ndv_flat_timer #(.FLAT_TICKS(FLAT_TICKS)) u_flat (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (go),
      .tick_i   (tick_i),
      .restart_i(load_ev),
      .expire_o (flat_ev)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         term_o  <= 1'b0;
         cause_q <= CAUSE_NONE;
         done_q  <= 1'b0;
         fa_q    <= 1'b0;
      end else begin
         fa_q   <= fast_active_i;
         term_o <= drop_hit || flat_hit;
         if (fast_active_i && !fa_q) cause_q <= CAUSE_NONE;
         if (drop_hit) begin
            cause_q <= CAUSE_DROP;
            done_q  <= 1'b1;
         end else if (flat_hit) begin
            cause_q <= CAUSE_FLAT;
            done_q  <= 1'b1;
         end
         if (!fast_active_i) done_q <= 1'b0;
      end
   end

   assign cause_o = cause_q;
endmodule

// File: rtl/ndv_term_checker.sv
module ndv_term_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       fast_active_i,
   input logic       hold_done,
   input logic       term_o,
   input logic [1:0] cause_o
);
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      term_o |=> !term_o);

   a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !fast_active_i |=> !term_o);

   a_r2_quiet_in_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_done |=> !term_o);

   a_r5_cause_on_term: assert property (@(posedge clk) disable iff (!rst_n)
      term_o |-> (cause_o == 2'b01 || cause_o == 2'b10));

   a_r8_cause_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fast_active_i) |=> (cause_o == 2'b00));

   a_r8_cause_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!term_o && !$past(fast_active_i && !$past(fast_active_i))) |-> $stable(cause_o));
endmodule

bind ndv_term_detect ndv_term_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fast_active_i(fast_active_i),
   .hold_done    (hold_done),
   .term_o       (term_o),
   .cause_o      (cause_o)
);

// File: tb/ndv_term_detect_bench.sv
`timescale 1ns/1ps
module ndv_term_detect_bench;
   localparam int VW = 16;
   localparam int TB_HOLD = 6;
   localparam int TB_SAMPLE = 4;
   localparam int TB_FLAT = 20;
   localparam int FLAT_K = TB_FLAT / TB_SAMPLE;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          fa = 1'b0;
   logic          sv = 1'b0;
   logic [VW-1:0] smp = '0;
   logic [VW-1:0] thr = 16'd4;
   logic          term_o;
   logic [1:0]    cause_o;

   int checks = 0;
   int fails = 0;
   int term_cnt = 0;
   int seq [0:15];

   always #2.5 clk = ~clk;

   ndv_term_detect #(
      .VW(VW), .HOLD_TICKS(TB_HOLD), .SAMPLE_TICKS(TB_SAMPLE), .FLAT_TICKS(TB_FLAT)
   ) u_ndv_term_detect (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .fast_active_i(fa),
      .sample_valid_i(sv), .sample_i(smp), .thr_i(thr),
      .term_o(term_o), .cause_o(cause_o)
   );

   always @(posedge clk) if (rst_n && term_o) term_cnt <= term_cnt + 1;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic give(input int v);
      @(negedge clk) begin sv = 1'b1; smp = VW'(v); end
      @(negedge clk) sv = 1'b0;
      @(negedge clk);
   endtask

   task automatic start_run();
      @(negedge clk) fa = 1'b1;
      @(negedge clk);
   endtask

   task automatic stop_run();
      @(negedge clk) fa = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // expected outcome: pos 2*i for a drop at sample i, 2*i+1 for flat after sample i
   function automatic void model(input int n, input int t, output int cause, output int pos);
      int peak = 0;
      bit have = 0;
      int since = 0;
      cause = 0; pos = -1;
      for (int i = 0; i < n; i++) begin
         if (!have || seq[i] > peak) begin
            peak = seq[i]; have = 1; since = 0;
         end else if (peak - seq[i] >= t) begin
            cause = 1; pos = 2 * i; return;
         end
         since++;
         if (since == FLAT_K) begin cause = 2; pos = 2 * i + 1; return; end
      end
   endfunction

   task automatic run_seq(input string tag, input int n, input int t);
      int base, pos_seen, ecause, epos;
      model(n, t, ecause, epos);
      thr = VW'(t);
      base = term_cnt;
      pos_seen = -1;
      start_run();
      ticks(TB_HOLD);
      for (int i = 0; i < n; i++) begin
         give(seq[i]);
         if (term_cnt > base) begin pos_seen = 2 * i; break; end
         ticks(TB_SAMPLE);
         @(negedge clk);
         if (term_cnt > base) begin pos_seen = 2 * i + 1; break; end
      end
      repeat (3) @(negedge clk);
      check({tag, " R5 R6 position"}, pos_seen, epos);
      check({tag, " R6 R5 cause"}, cause_o, ecause);
      check({tag, " R7 pulse count"}, term_cnt - base, (ecause != 0) ? 1 : 0);
      stop_run();
      check({tag, " R8 cause held after stop"}, cause_o, ecause);
   endtask

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int base;
      void'($urandom(32'd2711));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 term after reset", term_o, 0);
      check("R1 cause after reset", cause_o, 0);

      // R1: idle, strobes and ticks have no effect
      base = term_cnt;
      give(1000); ticks(TB_FLAT + 2); give(10);
      check("R1 no term while idle", term_cnt - base, 0);

      // R2: strobe one tick before hold-off end is ignored
      thr = 16'd4;
      base = term_cnt;
      start_run();
      ticks(TB_HOLD - 1);
      give(1000);
      ticks(1);
      give(900);               // loads peak if 1000 was ignored
      check("R2 early sample ignored", term_cnt - base, 0);
      // R3: second strobe in same slot ignored
      give(800);
      check("R3 extra strobe in slot ignored", term_cnt - base, 0);
      ticks(TB_SAMPLE);
      give(896);               // 900-896 = 4 >= 4
      check("R5 drop at threshold", term_cnt - base, 1);
      check("R5 drop cause", cause_o, 1);
      stop_run();

      // R8: cause cleared on next start; R9: old peak forgotten
      start_run();
      check("R8 cause cleared at start", cause_o, 0);
      base = term_cnt;
      ticks(TB_HOLD);
      give(500);
      ticks(TB_SAMPLE);
      give(497);               // gap 3 < 4
      check("R9 fresh peak, below-threshold gap", term_cnt - base, 0);
      ticks(TB_SAMPLE);
      give(600);               // R4 rise replaces peak
      ticks(TB_SAMPLE);
      give(597);
      check("R4 rise replaced peak (gap 3)", term_cnt - base, 0);
      ticks(TB_SAMPLE);
      give(596);
      check("R4 drop from new peak", term_cnt - base, 1);
      stop_run();

      // R6: exact flat window
      start_run();
      base = term_cnt;
      ticks(TB_HOLD);
      give(700);
      ticks(TB_FLAT - 1);
      @(negedge clk);
      check("R6 no flat one tick early", term_cnt - base, 0);
      ticks(1);
      @(negedge clk);
      check("R6 flat at window", term_cnt - base, 1);
      check("R6 flat cause", cause_o, 2);
      give(100);
      ticks(TB_FLAT);
      check("R7 single term per run", term_cnt - base, 1);
      stop_run();

      // directed sequences through the model
      seq[0] = 1000; seq[1] = 1002; seq[2] = 1001; seq[3] = 1000; seq[4] = 999;
      seq[5] = 1000; seq[6] = 1001;
      run_seq("flat-hover", 7, 4);
      seq[0] = 1200; seq[1] = 1195;
      run_seq("drop-first", 2, 5);
      seq[0] = 1200; seq[1] = 1196;
      run_seq("drop-below-thr", 2, 5);

      // constrained random runs
      for (int r = 0; r < 25; r++) begin
         int t, n;
         t = 1 + ($urandom % 8);
         n = 3 + ($urandom % 12);
         seq[0] = 1000 + ($urandom % 500);
         for (int i = 1; i < n; i++)
            seq[i] = seq[i-1] + int'($urandom % (t + 5)) - (t + 1);
         run_seq($sformatf("rand%0d", r), n, t);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule